// File: doc/BRIEF.md
# Programmable Output Macrocell Bank

This block is a row of logic output cells of the kind that sits behind the product-term array of a small programmable logic device. Each cell takes the product terms that the array produces for it and forms their sum. A cell can also add terms that a neighbouring cell has released. The sum passes through a polarity stage and then either leaves the cell directly or goes through a storage element. That element can act as a D, toggle, JK or set/reset flip-flop.

The storage element advances on a rising edge of the bank's shared cell clock or of a per-cell clock term, chosen per cell. Each cell also has preset and clear terms, and clear can come from either of two terms. A host data bus, one bit per cell, can force the flip-flop states and read them back. A per-cell selector picks the registered or the combinational value as the cell output. The same value returns on a feedback port so that it can re-enter the array.

The block runs on one system clock. Both the cell clock and the clock terms are sampled inputs, and the block acts on their rising edges.

Top module: `omc_bank`

## Requirements
- R1: With the combinational path selected, a cell's output is the OR of the native terms the cell keeps for itself, XORed with the cell's invert bit, with no clock delay.
- R2: Native term j of cell k goes to cell k+1 when cell k+1 sets take-from-below bit j, or to cell k-1 when cell k-1 sets take-from-above bit j. This happens only when cell k's lend bit j is set. A lent term no longer reaches its owner's sum, and a take request for a term that is not lent contributes nothing.
- R3: `cfg_err` goes high one clock after two cells request the same term, or after an end cell requests a term from beyond the bank. It falls one clock after the conflict is removed.
- R4: In D mode (mode code 0), a cell stores its polarity-corrected sum on the rising edge of its selected clock source. That source is the shared `cell_clk` when the cell's clock-select bit is 0, and its own clock term when the bit is 1. A steady high level or a falling edge stores nothing.
- R5: In toggle mode (mode code 1), a rising clock edge inverts the stored state when the sum is 1 and holds it when the sum is 0.
- R6: In JK mode (mode code 2), J is the sum and K is the cell's auxiliary term. J=1,K=0 sets; J=0,K=1 clears; J=K=0 holds; J=K=1 inverts.
- R7: In SR mode (mode code 3), S is the sum and R is the auxiliary term. S alone sets and R alone clears. S=R=1 holds the current state, as does S=R=0.
- R8: A preset term sets the state, and a clear term clears it, on the next system clock whether or not a cell clock edge occurs. Clear beats preset, and both beat a host load.
- R9: While `host_load` is high, every cell whose `host_sel` bit is set stores bit n of `host_wdata` (bit n for cell n) on the next clock, ahead of any cell clock edge. `host_rdata` bit n always shows cell n's stored state.
- R10: With the register path selected, a cell's output is its stored state. `fb_out` always equals `cell_out`.
- R11: After reset, every stored state is 0 and `cfg_err` is 0.
- R12: Either of a cell's two clear terms, alone, clears the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_clk | input | 1 | Shared cell clock, acted on at its rising edge |
| pt_native | input | NCELL*NTERM | Native product terms, cell i at bits i*NTERM and up |
| pt_aux | input | NCELL | Second logic term per cell (K or R) |
| pt_clk | input | NCELL | Per-cell clock term |
| pt_pre | input | NCELL | Per-cell preset term |
| pt_clr_a | input | NCELL | First clear term per cell |
| pt_clr_b | input | NCELL | Second clear term per cell |
| cfg_lend | input | NCELL*NTERM | Term released by its owner for neighbours |
| cfg_take_lo | input | NCELL*NTERM | Cell requests this term index from the cell below |
| cfg_take_hi | input | NCELL*NTERM | Cell requests this term index from the cell above |
| cfg_invert | input | NCELL | Polarity inversion per cell |
| cfg_mode | input | 2*NCELL | Flip-flop mode per cell: 0 D, 1 toggle, 2 JK, 3 SR |
| cfg_clk_sel | input | NCELL | 0 shared cell clock, 1 the cell's clock term |
| cfg_reg_sel | input | NCELL | 1 registered output, 0 combinational output |
| host_load | input | 1 | Host write strobe |
| host_sel | input | NCELL | Cells affected by a host write |
| host_wdata | input | NCELL | Host data bus, bit n for cell n |
| cell_out | output | NCELL | Cell outputs toward the pins |
| fb_out | output | NCELL | Feedback copy of the cell outputs |
| host_rdata | output | NCELL | Stored states for host read-back |
| cfg_err | output | 1 | Term-sharing conflict flag (registered) |

## Verification
The combinational path is tried with single terms, inverted empty sums and inverted non-empty sums. These cases separate the OR from the XOR. Sharing is tested in three settings: lend with take, take without lend, and lend with nobody taking. Together they show that a term is routed only when both sides agree, and that a lent term leaves its owner. Each flip-flop mode gets the full set of input pairs across several clock edges, so that hold, set, clear and invert each show up as a distinct state sequence. Levels and falling edges of the clock sources are applied to show that only a rising edge stores. Preset, clear, host load and a clock edge are applied together in several combinations to pin down their priority order.

// File: rtl/omc_pkg.sv
package omc_pkg;
  typedef enum logic [1:0] {
    FF_D  = 2'd0,
    FF_T  = 2'd1,
    FF_JK = 2'd2,
    FF_SR = 2'd3
  } ff_kind_e;
endpackage

// File: rtl/omc_term_router.sv
module omc_term_router #(
  parameter int NCELL = 8,
  parameter int NTERM = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCELL*NTERM-1:0] pt_native,
  input  logic [NCELL*NTERM-1:0] lend,
  input  logic [NCELL*NTERM-1:0] take_lo,
  input  logic [NCELL*NTERM-1:0] take_hi,
  output logic [NCELL-1:0]       sum,
  output logic                   err
);
  logic [NCELL*NTERM-1:0] own_use;
  logic [NCELL-1:0]       clash;

  assign own_use = pt_native & ~lend;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [NTERM-1:0] from_lo;
    logic [NTERM-1:0] from_hi;
    logic             edge_bad;
    if (i > 0) begin : g_lo
      assign from_lo = pt_native[(i-1)*NTERM +: NTERM] & lend[(i-1)*NTERM +: NTERM]
                     & take_lo[i*NTERM +: NTERM];
    end else begin : g_lo_none
      assign from_lo = '0;
    end
    if (i < NCELL-1) begin : g_hi
      assign from_hi = pt_native[(i+1)*NTERM +: NTERM] & lend[(i+1)*NTERM +: NTERM]
                     & take_hi[i*NTERM +: NTERM];
    end else begin : g_hi_none
      assign from_hi = '0;
    end
    // a request pointing beyond the bank, or a term wanted by both neighbours
    if (i == 0 && NCELL == 1) begin : g_solo
      assign edge_bad = |take_lo[i*NTERM +: NTERM] | |take_hi[i*NTERM +: NTERM];
      assign clash[i] = edge_bad;
    end else if (i == 0) begin : g_first
      assign edge_bad = |take_lo[i*NTERM +: NTERM];
      assign clash[i] = edge_bad;
    end else if (i == NCELL-1) begin : g_last
      assign edge_bad = |take_hi[i*NTERM +: NTERM];
      assign clash[i] = edge_bad;
    end else begin : g_mid
      assign edge_bad = 1'b0;
      assign clash[i] = |(take_lo[(i+1)*NTERM +: NTERM] & take_hi[(i-1)*NTERM +: NTERM]);
    end
    assign sum[i] = |own_use[i*NTERM +: NTERM] | |from_lo | |from_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= |clash;
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell
  import omc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sum,
  input  logic     invert,
  input  ff_kind_e mode,
  input  logic     clk_sel,
  input  logic     reg_sel,
  input  logic     shared_tick,
  input  logic     pt_clk,
  input  logic     pt_aux,
  input  logic     pt_pre,
  input  logic     pt_clr_a,
  input  logic     pt_clr_b,
  input  logic     host_load,
  input  logic     host_sel,
  input  logic     host_bit,
  output logic     cell_out,
  output logic     state_q
);
  logic pol;
  logic pt_clk_q;
  logic tick;
  logic clr_any;
  logic load_me;
  logic next_state;

  assign pol     = sum ^ invert;
  assign clr_any = pt_clr_a | pt_clr_b;
  assign load_me = host_load & host_sel;
  assign tick    = clk_sel ? (pt_clk & ~pt_clk_q) : shared_tick;

  always_ff @(posedge clk) begin
    if (rst) pt_clk_q <= 1'b0;
    else     pt_clk_q <= pt_clk;
  end

  always_comb begin
    next_state = state_q;
    unique case (mode)
      FF_D:  next_state = pol;
      FF_T:  next_state = state_q ^ pol;
      FF_JK: begin
        unique case ({pol, pt_aux})
          2'b10:   next_state = 1'b1;
          2'b01:   next_state = 1'b0;
          2'b11:   next_state = ~state_q;
          default: next_state = state_q;
        endcase
      end
      FF_SR: begin
        if (pol && !pt_aux)      next_state = 1'b1;
        else if (!pol && pt_aux) next_state = 1'b0;
        else                     next_state = state_q;
      end
      default: next_state = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state_q <= 1'b0;
    else if (clr_any) state_q <= 1'b0;
    else if (pt_pre)  state_q <= 1'b1;
    else if (load_me) state_q <= host_bit;
    else if (tick)    state_q <= next_state;
  end

  assign cell_out = reg_sel ? state_q : pol;

  // R8: clear has the last word
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (pt_clr_a || pt_clr_b) |=> !state_q);
  // R8: preset alone sets
  a_r8_preset_sets: assert property (@(posedge clk) disable iff (rst)
    (pt_pre && !pt_clr_a && !pt_clr_b) |=> state_q);
  // R9: host load stores the bus bit
  a_r9_host_load: assert property (@(posedge clk) disable iff (rst)
    (host_load && host_sel && !pt_pre && !pt_clr_a && !pt_clr_b)
      |=> (state_q == $past(host_bit)));
  // R4: nothing moves the state without an edge, load, preset or clear
  a_r4_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(host_load && host_sel) && !pt_pre && !pt_clr_a && !pt_clr_b)
      |=> $stable(state_q));
endmodule

// File: rtl/omc_bank.sv
module omc_bank
  import omc_pkg::*;
#(
  parameter int NCELL = 8,
  parameter int NTERM = 3,
  localparam int NPT  = NCELL * NTERM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cell_clk,
  input  logic [NPT-1:0]   pt_native,
  input  logic [NCELL-1:0] pt_aux,
  input  logic [NCELL-1:0] pt_clk,
  input  logic [NCELL-1:0] pt_pre,
  input  logic [NCELL-1:0] pt_clr_a,
  input  logic [NCELL-1:0] pt_clr_b,
  input  logic [NPT-1:0]   cfg_lend,
  input  logic [NPT-1:0]   cfg_take_lo,
  input  logic [NPT-1:0]   cfg_take_hi,
  input  logic [NCELL-1:0] cfg_invert,
  input  logic [2*NCELL-1:0] cfg_mode,
  input  logic [NCELL-1:0] cfg_clk_sel,
  input  logic [NCELL-1:0] cfg_reg_sel,
  input  logic             host_load,
  input  logic [NCELL-1:0] host_sel,
  input  logic [NCELL-1:0] host_wdata,
  output logic [NCELL-1:0] cell_out,
  output logic [NCELL-1:0] fb_out,
  output logic [NCELL-1:0] host_rdata,
  output logic             cfg_err
);
  logic [NCELL-1:0] sum;
  logic             cell_clk_q;
  logic             shared_tick;

  always_ff @(posedge clk) begin
    if (rst) cell_clk_q <= 1'b0;
    else     cell_clk_q <= cell_clk;
  end
  assign shared_tick = cell_clk & ~cell_clk_q;

  omc_term_router #(.NCELL(NCELL), .NTERM(NTERM)) u_router (
    .clk(clk), .rst(rst), .pt_native(pt_native), .lend(cfg_lend),
    .take_lo(cfg_take_lo), .take_hi(cfg_take_hi), .sum(sum), .err(cfg_err)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_mc
    omc_cell u_cell (
      .clk(clk), .rst(rst), .sum(sum[i]), .invert(cfg_invert[i]),
      .mode(ff_kind_e'(cfg_mode[2*i +: 2])), .clk_sel(cfg_clk_sel[i]),
      .reg_sel(cfg_reg_sel[i]), .shared_tick(shared_tick), .pt_clk(pt_clk[i]),
      .pt_aux(pt_aux[i]), .pt_pre(pt_pre[i]), .pt_clr_a(pt_clr_a[i]),
      .pt_clr_b(pt_clr_b[i]), .host_load(host_load), .host_sel(host_sel[i]),
      .host_bit(host_wdata[i]), .cell_out(cell_out[i]), .state_q(host_rdata[i])
    );
  end

  assign fb_out = cell_out;
endmodule

// File: tb/omc_bank_test.sv
module omc_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cell_clk = 1'b0;
  logic [NC*NT-1:0] pt_native = '0, cfg_lend = '0, cfg_take_lo = '0, cfg_take_hi = '0;
  logic [NC-1:0] pt_aux = '0, pt_clk = '0, pt_pre = '0, pt_clr_a = '0, pt_clr_b = '0;
  logic [NC-1:0] cfg_invert = '0, cfg_clk_sel = '0, cfg_reg_sel = '0;
  logic [2*NC-1:0] cfg_mode = '0;
  logic host_load = 1'b0;
  logic [NC-1:0] host_sel = '0, host_wdata = '0;
  logic [NC-1:0] cell_out, fb_out, host_rdata;
  logic cfg_err;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omc_bank #(.NCELL(NC), .NTERM(NT)) uut (
    .clk(clk), .rst(rst), .cell_clk(cell_clk), .pt_native(pt_native), .pt_aux(pt_aux),
    .pt_clk(pt_clk), .pt_pre(pt_pre), .pt_clr_a(pt_clr_a), .pt_clr_b(pt_clr_b),
    .cfg_lend(cfg_lend), .cfg_take_lo(cfg_take_lo), .cfg_take_hi(cfg_take_hi),
    .cfg_invert(cfg_invert), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
    .cfg_reg_sel(cfg_reg_sel), .host_load(host_load), .host_sel(host_sel),
    .host_wdata(host_wdata), .cell_out(cell_out), .fb_out(fb_out),
    .host_rdata(host_rdata), .cfg_err(cfg_err)
  );

  typedef struct {
    string      tag;
    logic [7:0] omask;
    logic [7:0] eout;
    logic [7:0] rmask;
    logic [7:0] erd;
    bit         chk_err;
    logic       eerr;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  // monitor: pops expected items and compares them with the ports
  initial forever begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (((cell_out & it.omask) !== (it.eout & it.omask)) ||
          ((host_rdata & it.rmask) !== (it.erd & it.rmask)) ||
          (it.chk_err && (cfg_err !== it.eerr))) begin
        errors++;
        $display("FAIL %s: out=%h rd=%h err=%b expected out=%h rd=%h err=%b (masks %h/%h)",
                 it.tag, cell_out, host_rdata, cfg_err, it.eout, it.erd, it.eerr,
                 it.omask, it.rmask);
      end
      checks++;
      if (fb_out !== cell_out) begin
        errors++;
        $display("FAIL R10 feedback: fb=%h expected %h", fb_out, cell_out);
      end
    end
  end

  task automatic sync();
    @(negedge clk);
    #2;
  endtask

  task automatic expect_bits(input string tag, input logic [7:0] om, input logic [7:0] eo,
                             input logic [7:0] rm, input logic [7:0] er);
    item_t it;
    @(posedge clk);
    #1;
    it.tag = tag; it.omask = om; it.eout = eo; it.rmask = rm; it.erd = er;
    it.chk_err = 1'b0; it.eerr = 1'b0;
    sb_q.push_back(it);
    -> chk_ev;
  endtask

  task automatic expect_err(input string tag, input logic e);
    item_t it;
    @(posedge clk);
    #1;
    it.tag = tag; it.omask = '0; it.eout = '0; it.rmask = '0; it.erd = '0;
    it.chk_err = 1'b1; it.eerr = e;
    sb_q.push_back(it);
    -> chk_ev;
  endtask

  task automatic pulse_cell_clk();
    sync(); cell_clk = 1'b1;
    @(posedge clk);
    sync(); cell_clk = 1'b0;
  endtask

  task automatic clear_all();
    sync(); pt_clr_a = '1;
    expect_bits("R12 clear all", 8'h00, 8'h00, 8'hFF, 8'h00);
    sync(); pt_clr_a = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    sync(); rst = 1'b0;
    // R11 reset state
    sb_q.push_back('{"R11 reset", 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b1, 1'b0});
    -> chk_ev;

    // R1 sum and polarity
    sync();
    pt_native[1] = 1'b1;            // cell0 term1
    cfg_invert[1] = 1'b1;           // cell1 inverted empty sum
    cfg_invert[2] = 1'b1; pt_native[6] = 1'b1; // cell2 inverted non-empty
    expect_bits("R1 sum/polarity", 8'h07, 8'h03, 8'h00, 8'h00);
    sync(); pt_native = '0; cfg_invert = '0;

    // R2 borrowing
    sync();
    pt_native[3] = 1'b1; cfg_lend[3] = 1'b1; cfg_take_lo[6] = 1'b1;
    expect_bits("R2 lend+take", 8'h07, 8'h04, 8'h00, 8'h00);
    sync(); cfg_take_lo[6] = 1'b0;
    expect_bits("R2 lend no taker", 8'h07, 8'h00, 8'h00, 8'h00);
    sync(); cfg_take_lo[6] = 1'b1; cfg_lend[3] = 1'b0;
    expect_bits("R2 take not lent", 8'h07, 8'h02, 8'h00, 8'h00);
    sync(); pt_native = '0; cfg_take_lo = '0;

    // R3 conflicts
    sync(); cfg_take_hi[3*NT+1] = 1'b1; cfg_take_lo[5*NT+1] = 1'b1;
    expect_err("R3 double grant", 1'b1);
    sync(); cfg_take_lo[5*NT+1] = 1'b0;
    expect_err("R3 conflict removed", 1'b0);
    sync(); cfg_take_hi = '0; cfg_take_lo[0] = 1'b1;
    expect_err("R3 request past end", 1'b1);
    sync(); cfg_take_lo = '0;
    expect_err("R3 clean", 1'b0);

    // R4 D mode, shared clock then term clock
    sync(); cfg_reg_sel[0] = 1'b1; pt_native[0] = 1'b1;
    expect_bits("R4 no edge", 8'h01, 8'h00, 8'h01, 8'h00);
    sync(); cell_clk = 1'b1;
    expect_bits("R4 rising edge", 8'h01, 8'h01, 8'h01, 8'h01);
    sync(); pt_native[0] = 1'b0;
    expect_bits("R4 level holds", 8'h01, 8'h01, 8'h01, 8'h01);
    sync(); cell_clk = 1'b0;
    expect_bits("R4 falling holds", 8'h01, 8'h01, 8'h01, 8'h01);
    sync(); cfg_clk_sel[1] = 1'b1; cfg_reg_sel[1] = 1'b1; pt_native[3] = 1'b1; pt_clk[1] = 1'b1;
    expect_bits("R4 term clock", 8'h02, 8'h02, 8'h02, 8'h02);
    sync(); pt_clk[1] = 1'b0; pt_native[3] = 1'b0;
    expect_bits("R4 term falling", 8'h02, 8'h02, 8'h02, 8'h02);

    // R5 toggle, cell2
    clear_all();
    sync(); cfg_mode[5:4] = 2'd1; cfg_reg_sel[2] = 1'b1; pt_native[6] = 1'b1;
    pulse_cell_clk();
    expect_bits("R5 toggle up", 8'h04, 8'h04, 8'h04, 8'h04);
    pulse_cell_clk();
    expect_bits("R5 toggle down", 8'h04, 8'h00, 8'h04, 8'h00);
    sync(); pt_native[6] = 1'b0;
    pulse_cell_clk();
    expect_bits("R5 zero holds", 8'h04, 8'h00, 8'h04, 8'h00);

    // R6 JK, cell3 (J = term 9, K = aux3)
    sync(); cfg_mode[7:6] = 2'd2; cfg_reg_sel[3] = 1'b1; pt_native[9] = 1'b1; pt_aux[3] = 1'b0;
    pulse_cell_clk();
    expect_bits("R6 J sets", 8'h08, 8'h08, 8'h08, 8'h08);
    sync(); pt_native[9] = 1'b0;
    pulse_cell_clk();
    expect_bits("R6 JK=00 holds", 8'h08, 8'h08, 8'h08, 8'h08);
    sync(); pt_native[9] = 1'b1; pt_aux[3] = 1'b1;
    pulse_cell_clk();
    expect_bits("R6 JK=11 inverts", 8'h08, 8'h00, 8'h08, 8'h00);
    pulse_cell_clk();
    expect_bits("R6 JK=11 inverts again", 8'h08, 8'h08, 8'h08, 8'h08);
    sync(); pt_native[9] = 1'b0;
    pulse_cell_clk();
    expect_bits("R6 K clears", 8'h08, 8'h00, 8'h08, 8'h00);
    sync(); pt_aux[3] = 1'b0;

    // R7 SR, cell4 (S = term 12, R = aux4)
    sync(); cfg_mode[9:8] = 2'd3; cfg_reg_sel[4] = 1'b1; pt_native[12] = 1'b1;
    pulse_cell_clk();
    expect_bits("R7 S sets", 8'h10, 8'h10, 8'h10, 8'h10);
    sync(); pt_aux[4] = 1'b1;
    pulse_cell_clk();
    expect_bits("R7 S=R=1 holds high", 8'h10, 8'h10, 8'h10, 8'h10);
    sync(); pt_native[12] = 1'b0;
    pulse_cell_clk();
    expect_bits("R7 R clears", 8'h10, 8'h00, 8'h10, 8'h00);
    sync(); pt_native[12] = 1'b1;
    pulse_cell_clk();
    expect_bits("R7 S=R=1 holds low", 8'h10, 8'h00, 8'h10, 8'h00);
    sync(); pt_native[12] = 1'b0; pt_aux[4] = 1'b0;

    // R8 / R12 preset, clear, priority, cell5
    sync(); cfg_reg_sel[5] = 1'b1; pt_pre[5] = 1'b1;
    expect_bits("R8 preset", 8'h20, 8'h20, 8'h20, 8'h20);
    sync(); pt_clr_a[5] = 1'b1;
    expect_bits("R8 clear beats preset", 8'h20, 8'h00, 8'h20, 8'h00);
    sync(); pt_clr_a[5] = 1'b0;
    expect_bits("R8 preset again", 8'h20, 8'h20, 8'h20, 8'h20);
    sync(); pt_pre[5] = 1'b0; pt_clr_b[5] = 1'b1;
    expect_bits("R12 second clear term", 8'h20, 8'h00, 8'h20, 8'h00);
    sync(); host_load = 1'b1; host_sel = 8'h20; host_wdata = 8'h20;
    expect_bits("R8 clear beats load", 8'h20, 8'h00, 8'h20, 8'h00);
    sync(); pt_clr_b[5] = 1'b0; pt_pre[5] = 1'b1; host_wdata = 8'h00;
    expect_bits("R8 preset beats load", 8'h20, 8'h20, 8'h20, 8'h20);
    sync(); pt_pre[5] = 1'b0; host_load = 1'b0; host_sel = '0;
    expect_bits("R8 state kept", 8'h20, 8'h20, 8'h20, 8'h20);

    // R9 host load and read-back
    clear_all();
    sync(); host_load = 1'b1; host_sel = 8'hF0; host_wdata = 8'h5A;
    expect_bits("R9 selected load", 8'h00, 8'h00, 8'hFF, 8'h50);
    sync(); host_load = 1'b0;
    expect_bits("R9 strobe low holds", 8'h00, 8'h00, 8'hFF, 8'h50);
    sync(); host_load = 1'b1; host_sel = 8'h80; host_wdata = 8'h80; cell_clk = 1'b1;
    expect_bits("R9 load beats edge", 8'h00, 8'h00, 8'h80, 8'h80);
    sync(); host_load = 1'b0; host_sel = '0; host_wdata = '0; cell_clk = 1'b0;

    // R10 output selector, cell7
    sync(); cfg_reg_sel[7] = 1'b1;
    expect_bits("R10 registered path", 8'h80, 8'h80, 8'h80, 8'h80);
    sync(); cfg_reg_sel[7] = 1'b0;
    expect_bits("R10 combinational path", 8'h80, 8'h00, 8'h80, 8'h80);
    sync(); cfg_invert[7] = 1'b1;
    expect_bits("R10 R1 comb inverted", 8'h80, 8'h80, 8'h80, 8'h80);

    sync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule